// File: doc/BRIEF.md
# Hierarchical Flash Address Counter

This block keeps the 13-bit page address used while a flash array is recorded or played back. The address is divided into three fields: a 2-bit block number at the top (bits 12:11), a 7-bit sector number in bits 10:4 and a 4-bit page number in bits 3:0. Each block holds 80 sectors, codes 0 to 79, and each sector holds 16 pages. The sector codes 80 to 127 do not exist, so stepping from the last page of sector 79 goes directly to sector 0 of the next block.

A controller first programs a start address and a stop address. It then loads the counter, with a flag that says whether a recording or a playback follows, and pulses `page_done` once for each page it finishes. The block reports when the counter passes its stop address, when a sector is completed, and when the counter is already at the final address and another page is requested. A readback port gives the address that software should see. This is the counter value, except in two cases: just after an address was programmed, the readback shows that programmed value, and after a stop or halt, it shows the address that was captured at that moment.

Top module: `flash_addr_counter`

## Requirements
- R1: After reset the counter and the readback are 0, the stop address is 0x1CFF, and `sector_end`, `stop_hit`, `mem_end` and `addr_err` are all 0.
- R2: A `load` pulse copies the start address into the counter. When `rec_mode` is 1, the page field (bits 3:0) is cleared. When `rec_mode` is 0, all 13 bits are used.
- R3: A `page_done` pulse with the page field below 15 adds one to the page field and leaves the block and sector fields unchanged.
- R4: A `page_done` pulse with page field 15 clears the page field, moves on to the next sector, and raises `sector_end` for one cycle.
- R5: A step from page 15 of sector 79 (0x4F) goes to page 0 of sector 0 in the next block. The counter never holds a sector code of 80 or above.
- R6: A `page_done` pulse when the counter is 0x1CFF leaves the counter at 0x1CFF and sets `mem_end`. `mem_end` stays at 1, and later `page_done` pulses do not move the counter, until the next `load`.
- R7: A `set_start` or `set_stop` whose sector field (bits 10:4) is 80 or more raises `addr_err` for one cycle. The stored address does not change, and the readback selection does not change.
- R8: After a valid `set_start` or `set_stop`, the readback shows the newly programmed address until the next `load`.
- R9: A `page_done` pulse while the counter equals the stop address raises `stop_hit` for one cycle. The counter still advances, and the readback holds the stop address until the next `load`.
- R10: A `halt` pulse captures the current counter value. The readback holds that value while later pages advance the counter. Whichever of halt or stop comes first is the value that is kept.
- R11: In all other cases, the readback equals the live counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_in | input | 13 | Address for set_start / set_stop |
| set_start | input | 1 | Program the start address |
| set_stop | input | 1 | Program the stop address |
| load | input | 1 | Load the counter from the start address |
| rec_mode | input | 1 | When set during load, align the start to a sector boundary |
| page_done | input | 1 | One page finished; advance the counter |
| halt | input | 1 | Stop request; capture the counter for readback |
| cnt_addr | output | 13 | Live counter value |
| rd_addr | output | 13 | Address selected for readback |
| sector_end | output | 1 | One-cycle pulse when the page field wraps |
| stop_hit | output | 1 | One-cycle pulse when a page is done at the stop address |
| mem_end | output | 1 | Level: a step was requested at the last address |
| addr_err | output | 1 | One-cycle pulse when a programmed address is invalid |

## Verification
The assertions assume that each control input is a single-cycle strobe and that at most one of `set_start`, `set_stop`, `load`, `page_done` and `halt` is active in any cycle. Each stimulus task in the bench drives exactly one strobe for one cycle and then releases it. Because of this, the bench never creates two requests in the same cycle, for which no ordering is defined. Every address the bench programs either has a valid sector code or is one of the deliberately invalid values used for R7.

// File: rtl/fac_pkg.sv
package fac_pkg;
  localparam int BLK_W       = 2;
  localparam int SEC_W       = 7;
  localparam int PG_W        = 4;
  localparam int SEC_PER_BLK = 80;
  localparam int ADDR_W      = BLK_W + SEC_W + PG_W;

  typedef logic [ADDR_W-1:0] addr_t;

  function automatic logic [PG_W-1:0] pg_of(addr_t a);
    return a[PG_W-1:0];
  endfunction

  function automatic logic [SEC_W-1:0] sec_of(addr_t a);
    return a[PG_W +: SEC_W];
  endfunction

  function automatic logic [BLK_W-1:0] blk_of(addr_t a);
    return a[ADDR_W-1 -: BLK_W];
  endfunction

  function automatic logic addr_ok(addr_t a);
    return sec_of(a) < SEC_W'(SEC_PER_BLK);
  endfunction

  function automatic addr_t sector_align(addr_t a);
    addr_t r;
    r = a;
    r[PG_W-1:0] = '0;
    return r;
  endfunction

  function automatic addr_t last_addr();
    return {{BLK_W{1'b1}}, SEC_W'(SEC_PER_BLK - 1), {PG_W{1'b1}}};
  endfunction

  function automatic logic page_wraps(addr_t a);
    return pg_of(a) == {PG_W{1'b1}};
  endfunction

  function automatic addr_t next_page(addr_t a);
    addr_t r;
    r = a;
    if (!page_wraps(a)) begin
      r[PG_W-1:0] = pg_of(a) + PG_W'(1);
    end else if (sec_of(a) != SEC_W'(SEC_PER_BLK - 1)) begin
      r[PG_W-1:0]     = '0;
      r[PG_W +: SEC_W] = sec_of(a) + SEC_W'(1);
    end else if (blk_of(a) != {BLK_W{1'b1}}) begin
      r[PG_W-1:0]       = '0;
      r[PG_W +: SEC_W]  = '0;
      r[ADDR_W-1 -: BLK_W] = blk_of(a) + BLK_W'(1);
    end
    return r;
  endfunction
endpackage

// File: rtl/fac_bounds.sv
module fac_bounds
  import fac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  addr_t addr_in,
  input  logic  set_start,
  input  logic  set_stop,
  output addr_t start_q,
  output addr_t stop_q,
  output logic  prog_we,
  output addr_t prog_val,
  output logic  addr_err
);
  logic in_ok;
  logic start_we, stop_we, bad_req;

  assign in_ok    = addr_ok(addr_in);
  assign start_we = set_start && in_ok;
  assign stop_we  = set_stop && in_ok;
  assign bad_req  = (set_start || set_stop) && !in_ok;
  assign prog_we  = start_we || stop_we;
  assign prog_val = addr_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= '0;
      stop_q   <= last_addr();
      addr_err <= 1'b0;
    end else begin
      addr_err <= bad_req;
      if (start_we) start_q <= addr_in;
      if (stop_we)  stop_q  <= addr_in;
    end
  end

  assert_bad_start_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_start && !addr_ok(addr_in) |=> $stable(start_q) && addr_err);
  assert_bad_stop_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_stop && !addr_ok(addr_in) |=> $stable(stop_q) && addr_err);
endmodule

// File: rtl/fac_counter.sv
module fac_counter
  import fac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  rec_mode,
  input  logic  page_done,
  input  addr_t start_q,
  input  addr_t stop_q,
  output addr_t cnt_q,
  output logic  stop_cross,
  output logic  sector_end,
  output logic  stop_hit,
  output logic  mem_end
);
  logic  at_last, step_ok, wrap_ev;
  addr_t load_val, step_val;

  assign load_val   = rec_mode ? sector_align(start_q) : start_q;
  assign step_val   = next_page(cnt_q);
  assign at_last    = cnt_q == last_addr();
  assign step_ok    = page_done && !mem_end && !at_last;
  assign wrap_ev    = page_done && !mem_end && page_wraps(cnt_q);
  assign stop_cross = page_done && (cnt_q == stop_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      sector_end <= 1'b0;
      stop_hit   <= 1'b0;
      mem_end    <= 1'b0;
    end else begin
      sector_end <= wrap_ev;
      stop_hit   <= stop_cross;
      if (load) begin
        cnt_q   <= load_val;
        mem_end <= 1'b0;
      end else if (step_ok) begin
        cnt_q <= step_val;
      end else if (page_done && at_last) begin
        mem_end <= 1'b1;
      end
    end
  end

  assert_load_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load && rec_mode |=> pg_of(cnt_q) == '0);
  assert_page_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    page_done && !load && !mem_end && !page_wraps(cnt_q) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_sector_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sector_end |-> $past(page_done) && pg_of($past(cnt_q)) == {PG_W{1'b1}});
  assert_sector_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_of(cnt_q) < SEC_W'(SEC_PER_BLK));
  assert_end_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_end && !load |=> mem_end && $stable(cnt_q));
endmodule

// File: rtl/fac_readback.sv
module fac_readback
  import fac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  prog_we,
  input  addr_t prog_val,
  input  logic  halt,
  input  logic  stop_cross,
  input  addr_t cnt_q,
  output addr_t rd_addr
);
  logic  show_prog, held;
  addr_t prog_q, snap_q;
  logic  capture;

  assign capture = (halt || stop_cross) && !held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      show_prog <= 1'b0;
      held      <= 1'b0;
      prog_q    <= '0;
      snap_q    <= '0;
    end else begin
      if (load) begin
        show_prog <= 1'b0;
        held      <= 1'b0;
      end else begin
        if (prog_we) begin
          show_prog <= 1'b1;
          prog_q    <= prog_val;
        end
        if (capture) begin
          held   <= 1'b1;
          snap_q <= cnt_q;
        end
      end
    end
  end

  always_comb begin
    if (show_prog)  rd_addr = prog_q;
    else if (held)  rd_addr = snap_q;
    else            rd_addr = cnt_q;
  end

  assert_prog_shown_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we && !load |=> rd_addr == $past(prog_val));
  assert_snapshot_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    held && !show_prog && !prog_we && !load |=> $stable(rd_addr));
  assert_live_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rd_addr == cnt_q);
endmodule

// File: rtl/flash_addr_counter.sv
module flash_addr_counter
  import fac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              set_start,
  input  logic              set_stop,
  input  logic              load,
  input  logic              rec_mode,
  input  logic              page_done,
  input  logic              halt,
  output logic [ADDR_W-1:0] cnt_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              sector_end,
  output logic              stop_hit,
  output logic              mem_end,
  output logic              addr_err
);
  addr_t start_q, stop_q, prog_val, cnt_q, rd_q;
  logic  prog_we, stop_cross;

  fac_bounds u_bounds (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .set_start(set_start), .set_stop(set_stop),
    .start_q(start_q), .stop_q(stop_q),
    .prog_we(prog_we), .prog_val(prog_val), .addr_err(addr_err)
  );

  fac_counter u_counter (
    .clk(clk), .rst_n(rst_n), .load(load), .rec_mode(rec_mode),
    .page_done(page_done), .start_q(start_q), .stop_q(stop_q),
    .cnt_q(cnt_q), .stop_cross(stop_cross), .sector_end(sector_end),
    .stop_hit(stop_hit), .mem_end(mem_end)
  );

  fac_readback u_readback (
    .clk(clk), .rst_n(rst_n), .load(load), .prog_we(prog_we),
    .prog_val(prog_val), .halt(halt), .stop_cross(stop_cross),
    .cnt_q(cnt_q), .rd_addr(rd_q)
  );

  assign cnt_addr = cnt_q;
  assign rd_addr  = rd_q;

  assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({set_start, set_stop, load, page_done, halt}) <= 1);
endmodule

// File: tb/flash_addr_counter_test.sv
module flash_addr_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] addr_in = '0;
  logic        set_start = 0, set_stop = 0, load = 0, rec_mode = 0, page_done = 0, halt = 0;
  logic [12:0] cnt_addr, rd_addr;
  logic        sector_end, stop_hit, mem_end, addr_err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct { string tag; int sel; int exp; } item_t;
  item_t q[$];
  event smp;

  flash_addr_counter uut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .set_start(set_start),
    .set_stop(set_stop), .load(load), .rec_mode(rec_mode), .page_done(page_done),
    .halt(halt), .cnt_addr(cnt_addr), .rd_addr(rd_addr), .sector_end(sector_end),
    .stop_hit(stop_hit), .mem_end(mem_end), .addr_err(addr_err)
  );

  always #2 clk = ~clk;

  function automatic int probe(int sel);
    case (sel)
      0: return int'(rd_addr);
      1: return int'(cnt_addr);
      2: return int'(sector_end);
      3: return int'(stop_hit);
      4: return int'(mem_end);
      default: return int'(addr_err);
    endcase
  endfunction

  // bench model of the address step: linear page index across the whole array
  function automatic int model_next(int a);
    int lin;
    lin = (a >> 11) * 1280 + ((a >> 4) & 127) * 16 + (a & 15);
    if (lin < 4 * 1280 - 1) lin = lin + 1;
    return ((lin / 1280) << 11) | (((lin % 1280) / 16) << 4) | (lin % 16);
  endfunction

  always @(smp) begin
    while (q.size() > 0) begin
      item_t it;
      int got;
      it = q.pop_front();
      got = probe(it.sel);
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, got, it.exp);
      end
    end
  end

  task automatic expect_v(string tag, int sel, int exp);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic flush();
    -> smp;
    #1;
  endtask

  // one strobe for one cycle; outputs are settled at the following negedge
  task automatic strobe(int kind, int a, bit rm);
    @(negedge clk);
    addr_in = 13'(a); rec_mode = rm;
    case (kind)
      0: set_start = 1;
      1: set_stop = 1;
      2: load = 1;
      3: page_done = 1;
      default: halt = 1;
    endcase
    @(posedge clk);
    @(negedge clk);
    set_start = 0; set_stop = 0; load = 0; page_done = 0; halt = 0;
  endtask

  task automatic pages(int n);
    for (int i = 0; i < n; i++) strobe(3, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    expect_v("R1 cnt", 1, 0); expect_v("R1 rd", 0, 0);
    expect_v("R1 sector_end", 2, 0); expect_v("R1 stop_hit", 3, 0);
    expect_v("R1 mem_end", 4, 0); expect_v("R1 addr_err", 5, 0);
    flush();

    // R8 programmed start shown; R2 play load keeps full address; R11 live
    strobe(0, 'h0123, 0);
    expect_v("R8 rd start", 0, 'h0123); expect_v("R7 no err", 5, 0); flush();
    strobe(2, 0, 0);
    expect_v("R2 play load", 1, 'h0123); expect_v("R11 rd live", 0, 'h0123); flush();
    pages(12);
    expect_v("R3 page step", 1, 'h012F); expect_v("R4 no wrap yet", 2, 0); flush();
    pages(1);
    expect_v("R4 sector step", 1, 'h0130); expect_v("R4 pulse", 2, 1); flush();
    pages(1);
    expect_v("R3 next page", 1, 'h0131); expect_v("R4 pulse gone", 2, 0);
    expect_v("R11 rd follows", 0, 'h0131); flush();

    // R2 record alignment; R5 block skip
    strobe(0, 'h04F7, 0);
    strobe(2, 0, 1);
    expect_v("R2 rec aligned", 1, 'h04F0); flush();
    pages(15);
    expect_v("R5 last page", 1, 'h04FF); flush();
    pages(1);
    expect_v("R5 next block", 1, 'h0800); expect_v("R4 pulse at block", 2, 1); flush();

    // R7 invalid addresses rejected
    strobe(0, 'h0D00, 0);
    expect_v("R7 err start", 5, 1); expect_v("R7 rd unchanged", 0, 'h0800); flush();
    strobe(1, 'h1FFF, 0);
    expect_v("R7 err stop", 5, 1); expect_v("R7 rd unchanged2", 0, 'h0800); flush();
    strobe(2, 0, 0);
    expect_v("R7 start kept", 1, 'h04F7); flush();

    // R9 stop compare
    strobe(1, 'h04F9, 0);
    expect_v("R8 rd stop", 0, 'h04F9); flush();
    strobe(2, 0, 0);
    expect_v("R11 rd after load", 0, 'h04F7); flush();
    pages(2);
    expect_v("R9 at stop no hit", 3, 0); expect_v("R9 cnt", 1, 'h04F9); flush();
    pages(1);
    expect_v("R9 hit", 3, 1); expect_v("R9 cnt moves", 1, 'h04FA);
    expect_v("R9 rd snap", 0, 'h04F9); flush();
    pages(4);
    expect_v("R9 hit gone", 3, 0); expect_v("R9 rd held", 0, 'h04F9);
    expect_v("R9 cnt", 1, 'h04FE); flush();

    // R10 halt capture, first wins over later stop
    strobe(2, 0, 0);
    pages(1);
    strobe(4, 0, 0);
    expect_v("R10 rd captured", 0, 'h04F8); flush();
    pages(3);
    expect_v("R10 cnt moves", 1, 'h04FB); expect_v("R10 rd held", 0, 'h04F8); flush();

    // R6 end of memory
    strobe(0, 'h1CFE, 0);
    strobe(1, 'h1CFF, 0);
    strobe(2, 0, 0);
    pages(1);
    expect_v("R6 at last", 1, 'h1CFF); expect_v("R6 not yet", 4, 0); flush();
    pages(1);
    expect_v("R6 cnt held", 1, 'h1CFF); expect_v("R6 mem_end", 4, 1);
    expect_v("R9 hit at end", 3, 1); flush();
    pages(2);
    expect_v("R6 still held", 1, 'h1CFF); expect_v("R6 sticky", 4, 1); flush();
    strobe(2, 0, 0);
    expect_v("R6 cleared by load", 4, 0); expect_v("R6 reload", 1, 'h1CFE); flush();

    // R3 R4 R5 sweep against linear model
    strobe(0, 'h04A0, 0);
    strobe(2, 0, 0);
    a = 'h04A0;
    for (int i = 0; i < 300; i++) begin
      bit wrap;
      wrap = (a & 15) == 15;
      pages(1);
      a = model_next(a);
      expect_v("R5 sweep cnt", 1, a);
      expect_v("R4 sweep wrap", 2, int'(wrap));
      flush();
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule